// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with LRU Replacement

This block is a small read/write cache between a processor port and a slower backing memory. Each block holds two words. A set index drawn from the address picks one set, and the two ways of that set are compared against the address tag in the same cycle. A read that hits returns the word in the same cycle as the request. A write that hits updates one word of the way that hit.

A miss stalls the processor. A small refill engine then reads the two words of the block from backing memory, lower address first, with one request/acknowledge handshake per word. When the second word arrives, the block goes into a free way or into the least recently used way of the set, and the access completes in that cycle. Each set keeps a single LRU bit that names its victim. Two free-running counters record completed hits and completed misses.

The processor holds its request steady until `cpuReady` is high. Blocks are never written back: a write changes only the cached copy.

Top module: `twoway_lru_cache`

## Requirements
- R1: After reset both ways of every set are invalid, `hitCount` and `missCount` are zero, and `cpuReady` and `memReq` are low.
- R2: Addresses are word aligned. Byte-address bit 2 selects word 0 or word 1 of a block, bits [10:3] select one of 256 sets, and bits [31:11] form the 21-bit tag.
- R3: Both ways of the selected set are compared at once. On a hit in either way, `cpuReady` is high in the same cycle as `cpuReq`, and a read returns that way's addressed word with no memory traffic.
- R4: On a miss the block is fetched as two words in ascending order. `memAddr` is first the block base and then base+4. `memReq` stays high until each word's `memAck`.
- R5: Each set keeps one LRU bit that names the way not most recently accessed. The bit is updated on every hit and on every refill.
- R6: On a miss the victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the LRU bit.
- R7: The processor is stalled (`cpuReady` low) until the second word is acknowledged. In that cycle `cpuReady` is high and a read returns the requested word. Tag and valid bit are written only then.
- R8: A write hit replaces only the addressed word of the hitting way and marks that way most recently used.
- R9: A write miss allocates the block. The write data replaces the addressed word of the fetched block, and the other word keeps the fetched value.
- R10: Each completed access increments exactly one counter: `hitCount` for a hit, `missCount` for a miss. A miss is never also counted as a hit.
- R11: From an empty cache, byte addresses 0, 4, 8188, 0, 16384, 0 give 3 hits and 3 misses. Address 16384 lands in way 1 of set 0 and does not evict address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Word-aligned byte address |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Read data, valid while cpuReady is high |
| cpuReady | output | 1 | Access completes this cycle |
| memReq | output | 1 | Refill word request to backing memory |
| memAddr | output | 32 | Byte address of the requested refill word |
| memAck | input | 1 | Backing memory delivers memRdata this cycle |
| memRdata | input | 32 | Refill word from backing memory |
| hitCount | output | 16 | Number of completed hits (wraps) |
| missCount | output | 16 | Number of completed misses (wraps) |

## Verification
The bench builds the cache with its default parameters: 32-bit addresses and words, 256 sets and 16-bit counters. This keeps the 21-bit tag and the set-255 aliasing of address 8188 exactly as the requirements state them, so the six-access trace can be checked hit for hit. With three block addresses that share set 0, the bench reaches LRU eviction on both ways. It also varies the backing-memory latency, which shows that the stall lasts until the second acknowledge whatever the wait.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_FETCH0 = 2'd1,
    ST_FETCH1 = 2'd2
  } fillState_t;

  typedef struct packed {
    logic accessHit;
    logic startMiss;
    logic captureFirst;
    logic fillDone;
  } ctrlStrobes_t;

endpackage

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         lookupHit,
  input  logic         memAck,
  output ctrlStrobes_t strobe,
  output logic         memReq,
  output logic         cpuReady
);

  fillState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOOKUP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    cpuReady  = 1'b0;
    unique case (state)
      ST_LOOKUP: begin
        if (cpuReq) begin
          if (lookupHit) begin
            strobe.accessHit = 1'b1;
            cpuReady         = 1'b1;
          end else begin
            strobe.startMiss = 1'b1;
            stateNext        = ST_FETCH0;
          end
        end
      end
      ST_FETCH0: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.captureFirst = 1'b1;
          stateNext           = ST_FETCH1;
        end
      end
      ST_FETCH1: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillDone = 1'b1;
          cpuReady        = 1'b1;
          stateNext       = ST_LOOKUP;
        end
      end
      default: stateNext = ST_LOOKUP;
    endcase
  end

  // R7: a refill word still outstanding keeps the processor stalled
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |-> !cpuReady);

  // R4: the first acknowledged word is always followed by a second request
  assert_second_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH0 && memAck) |=> memReq);

endmodule

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SET_BITS = 8,
  parameter int CNT_W    = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strobe,
  input  logic                            cpuWe,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] cpuWordAddr,
  input  logic [DATA_W-1:0]               cpuWdata,
  output logic                            lookupHit,
  output logic [DATA_W-1:0]               cpuRdata,
  output logic [ADDR_W-1:0]               memAddr,
  input  logic [DATA_W-1:0]               memRdata,
  output logic [CNT_W-1:0]                hitCount,
  output logic [CNT_W-1:0]                missCount
);

  localparam int BYTE_BITS = $clog2(DATA_W / 8);
  localparam int WA_W      = ADDR_W - BYTE_BITS;
  localparam int TAG_W     = WA_W - SET_BITS - 1;
  localparam int SETS      = 1 << SET_BITS;
  localparam int WAYS      = 2;

  logic [SET_BITS-1:0] curIdx, missIdx;
  logic [TAG_W-1:0]    curTag, missTag;
  logic                curWord, missWord;

  logic [WA_W-1:0]     missAddrQ;
  logic                victimQ;
  logic                wordPtrQ;
  logic [DATA_W-1:0]   firstWordQ;

  logic [WAYS-1:0]     hitVec;
  logic [WAYS-1:0]     validVec;
  logic [DATA_W-1:0]   readWord [WAYS];
  logic [SETS-1:0]     lruBits;
  logic                hitWay;
  logic                victimNow;
  logic [DATA_W-1:0]   fillW0, fillW1;

  assign curWord  = cpuWordAddr[0];
  assign curIdx   = cpuWordAddr[SET_BITS:1];
  assign curTag   = cpuWordAddr[WA_W-1:SET_BITS+1];
  assign missWord = missAddrQ[0];
  assign missIdx  = missAddrQ[SET_BITS:1];
  assign missTag  = missAddrQ[WA_W-1:SET_BITS+1];

  // Per-way storage and comparator
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [DATA_W-1:0] dataMem [SETS][2];
    logic [SETS-1:0]   validMem;
    logic              wrHit, wrFill;

    assign wrHit  = strobe.accessHit && cpuWe && hitVec[w];
    assign wrFill = strobe.fillDone && (victimQ == 1'(w));

    assign validVec[w] = validMem[curIdx];
    assign hitVec[w]   = validMem[curIdx] && (tagMem[curIdx] == curTag);
    assign readWord[w] = dataMem[curIdx][curWord];

    always_ff @(posedge clk) begin
      if (!rstN) validMem <= '0;
      else if (wrFill) validMem[missIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrFill) begin
        tagMem[missIdx]     <= missTag;
        dataMem[missIdx][0] <= fillW0;
        dataMem[missIdx][1] <= fillW1;
      end else if (wrHit) begin
        dataMem[curIdx][curWord] <= cpuWdata;
      end
    end
  end

  assign lookupHit = |hitVec;
  assign hitWay    = hitVec[1];

  // Victim: first free way, then the least recently used one
  always_comb begin
    if (!validVec[0])      victimNow = 1'b0;
    else if (!validVec[1]) victimNow = 1'b1;
    else                   victimNow = lruBits[curIdx];
  end

  // Miss bookkeeping for the refill sequence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      missAddrQ  <= '0;
      victimQ    <= 1'b0;
      wordPtrQ   <= 1'b0;
      firstWordQ <= '0;
    end else begin
      if (strobe.startMiss) begin
        missAddrQ <= cpuWordAddr;
        victimQ   <= victimNow;
        wordPtrQ  <= 1'b0;
      end
      if (strobe.captureFirst) begin
        firstWordQ <= memRdata;
        wordPtrQ   <= 1'b1;
      end
    end
  end

  assign memAddr = {missAddrQ[WA_W-1:1], wordPtrQ, {BYTE_BITS{1'b0}}};

  // Write-miss merge into the fetched block
  assign fillW0 = (cpuWe && !missWord) ? cpuWdata : firstWordQ;
  assign fillW1 = (cpuWe &&  missWord) ? cpuWdata : memRdata;

  always_comb begin
    if (strobe.fillDone) cpuRdata = missWord ? fillW1 : fillW0;
    else                 cpuRdata = readWord[hitWay];
  end

  // LRU bits: point at the way not just touched
  always_ff @(posedge clk) begin
    if (!rstN) lruBits <= '0;
    else if (strobe.accessHit) lruBits[curIdx]  <= ~hitWay;
    else if (strobe.fillDone)  lruBits[missIdx] <= ~victimQ;
  end

  // Access counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (strobe.accessHit) hitCount  <= hitCount + 1'b1;
      if (strobe.fillDone)  missCount <= missCount + 1'b1;
    end
  end

  // R3: a block never sits in both ways of a set
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R5: after a hit the set's LRU bit names the other way
  assert_lru_update_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accessHit |=> (lruBits[$past(curIdx)] == !$past(hitWay)));

  // R10: counters never advance together and step by one
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount != $past(hitCount)) |->
      (hitCount == $past(hitCount) + 1'b1) && (missCount == $past(missCount)));

  // R6: a refilled block becomes visible with valid set after completion
  assert_fill_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillDone |=> ($past(victimQ) ? g_way[1].validMem[$past(missIdx)]
                                         : g_way[0].validMem[$past(missIdx)]));

endmodule

// File: rtl/twoway_lru_cache.sv
module twoway_lru_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SET_BITS = 8,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int BYTE_BITS = $clog2(DATA_W / 8);

  ctrlStrobes_t strobe;
  logic         lookupHit;

  cache_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .lookupHit(lookupHit),
    .memAck   (memAck),
    .strobe   (strobe),
    .memReq   (memReq),
    .cpuReady (cpuReady)
  );

  cache_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SET_BITS(SET_BITS),
    .CNT_W   (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuWe      (cpuWe),
    .cpuWordAddr(cpuAddr[ADDR_W-1:BYTE_BITS]),
    .cpuWdata   (cpuWdata),
    .lookupHit  (lookupHit),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memRdata   (memRdata),
    .hitCount   (hitCount),
    .missCount  (missCount)
  );

  // R2: requests carry word-aligned addresses
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (cpuAddr[BYTE_BITS-1:0] == '0));

  // R4: refill words go out in ascending order within one block
  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !memAddr[BYTE_BITS]) |=>
      (memReq && memAddr[BYTE_BITS] &&
       memAddr[ADDR_W-1:BYTE_BITS+1] == $past(memAddr[ADDR_W-1:BYTE_BITS+1])));

endmodule

// File: tb/test_twoway_lru_cache.sv
module test_twoway_lru_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady, memReq, memAck = 1'b0;
  logic [31:0] memAddr, memRdata = '0;
  logic [15:0] hitCount, missCount;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  twoway_lru_cache i_twoway_lru_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .hitCount(hitCount), .missCount(missCount)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h3C00_0000;
  endfunction

  // Backing memory: acknowledges after memLat idle cycles, logs addresses
  int          memLat = 0;
  int          waitCnt = 0;
  int          logIdx = 0;
  logic [31:0] addrLog [64];

  always @(posedge clk) begin
    #2;
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt >= memLat) begin
        memAck   = 1'b1;
        memRdata = memWord(memAddr);
        addrLog[logIdx % 64] = memAddr;
        logIdx++;
        waitCnt = 0;
      end else waitCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] lastData;
  int          lastAcks;
  int          firstLog;
  bit          stallOk;

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
    int start = logIdx;
    stallOk = 1'b1;
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (cpuReady) begin
        lastData = cpuRdata;
        if ((logIdx - start) != 0 && (logIdx - start) != 2) stallOk = 1'b0;
        break;
      end
    end
    lastAcks = logIdx - start;
    firstLog = start;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  // Read trace: address and whether a miss is expected
  localparam int NVEC = 10;
  localparam logic [31:0] vAddr [NVEC] = '{32'd0, 32'd4, 32'd8188, 32'd0, 32'd16384,
                                           32'd0, 32'd32768, 32'd0, 32'd16384, 32'd0};
  localparam bit vMiss [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                  1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  initial begin
    #20000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] h0, m0;
    logic [31:0] base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!cpuReady && !memReq, "R1 ready/req in reset", {30'd0, cpuReady, memReq}, 32'd0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(hitCount == 0 && missCount == 0, "R1 counters", {hitCount, missCount}, 32'd0);

    // Table-driven trace, memory latency varied per row
    for (int i = 0; i < NVEC; i++) begin
      memLat = i % 3;
      h0 = hitCount; m0 = missCount;
      access(1'b0, vAddr[i], 32'd0);
      check(lastData == memWord(vAddr[i]), "R2/R3 read data", lastData, memWord(vAddr[i]));
      check(lastAcks == (vMiss[i] ? 2 : 0), "R6 hit/miss outcome", lastAcks, vMiss[i] ? 2 : 0);
      check(stallOk, "R7 stall until second word", {31'd0, stallOk}, 32'd1);
      @(negedge clk);
      check(hitCount == h0 + (vMiss[i] ? 0 : 1) && missCount == m0 + (vMiss[i] ? 1 : 0),
            "R10 counter step", {hitCount, missCount},
            {h0 + 16'(!vMiss[i]), m0 + 16'(vMiss[i])});
      if (vMiss[i]) begin
        base = {vAddr[i][31:3], 3'b000};
        check(addrLog[firstLog % 64] == base && addrLog[(firstLog + 1) % 64] == base + 4,
              "R4 refill order", addrLog[(firstLog + 1) % 64], base + 4);
      end
      if (i == 5)
        check(hitCount == 3 && missCount == 3, "R11 trace totals",
              {hitCount, missCount}, {16'd3, 16'd3});
    end
    // Set 0 now: way0=0, way1=16384, LRU names way1 (0 just read)

    // R8: write hit changes only the addressed word
    memLat = 1;
    access(1'b1, 32'd4, 32'hDEAD_BEEF);
    check(lastAcks == 0, "R8 write hit no refill", lastAcks, 0);
    access(1'b0, 32'd4, 32'd0);
    check(lastData == 32'hDEAD_BEEF && lastAcks == 0, "R8 written word", lastData, 32'hDEAD_BEEF);
    access(1'b0, 32'd0, 32'd0);
    check(lastData == memWord(0), "R8 neighbour word kept", lastData, memWord(0));

    // R8/R5: write hit on way1 marks it MRU, so next miss evicts way0 (address 0)
    access(1'b1, 32'd16388, 32'h1234_5678);
    access(1'b0, 32'd32768, 32'd0);
    check(lastAcks == 2, "R5 miss after MRU write", lastAcks, 2);
    access(1'b0, 32'd16388, 32'd0);
    check(lastAcks == 0 && lastData == 32'h1234_5678, "R8 MRU way survived", lastData,
          32'h1234_5678);
    access(1'b0, 32'd4, 32'd0);
    check(lastAcks == 2 && lastData == memWord(4), "R6 LRU way evicted", lastData, memWord(4));

    // R9: write miss allocates and merges
    memLat = 3;
    h0 = hitCount; m0 = missCount;
    access(1'b1, 32'h0000_2014, 32'hCAFE_F00D);
    check(lastAcks == 2, "R9 write miss refills", lastAcks, 2);
    @(negedge clk);
    check(missCount == m0 + 1 && hitCount == h0, "R10 write miss counted once",
          {hitCount, missCount}, {h0, m0 + 16'd1});
    access(1'b0, 32'h0000_2014, 32'd0);
    check(lastAcks == 0 && lastData == 32'hCAFE_F00D, "R9 merged word", lastData, 32'hCAFE_F00D);
    access(1'b0, 32'h0000_2010, 32'd0);
    check(lastAcks == 0 && lastData == memWord(32'h2010), "R9 fetched word", lastData,
          memWord(32'h2010));

    // R2: high tag bits distinguish blocks in the same set
    access(1'b0, 32'h8000_2010, 32'd0);
    check(lastAcks == 2 && lastData == memWord(32'h8000_2010), "R2 tag top bit", lastData,
          memWord(32'h8000_2010));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule